// File: doc/BRIEF.md
# SDRAM Controller Configuration Register File

This block holds the software-visible configuration and status registers of an SDRAM controller. Software reaches them indirectly through two bus addresses. One of them is an index register that holds an internal register offset. The other is a data window that reads or writes the register selected by that offset. Behind the window sit the following registers:

- two write-1-to-clear error status registers, which hardware sets through error inputs;
- an error address register;
- a global configuration register with an enable bit and a self-refresh bit;
- a read-only status register that follows edges of those two configuration bits;
- refresh, power-management and timing registers with write masks;
- an ECC configuration register and an ECC error status register;
- four bank configuration registers.

The block drives two outputs. The ECC error interrupt is high while the ECC error status is non-zero. The controller-enable output goes to the bank decoder. Command sequencing and the DRAM physical interface are outside this block. Every access is a single-cycle strobe. Read data is registered and is valid in the cycle after the read strobe.

Top module: `sdram_cfg_regs`

## Requirements
- R1: A write to bus address 0x10 stores the low 8 bits of the data as the index. A read of 0x10 returns the index, zero-extended. Read data for any read strobe appears on bus_rdata one clock after the strobe and then holds.
- R2: Bus address 0x11 reads and writes the register at the current index. Implemented offsets are:
  - 0x00 error status A
  - 0x08 error status B
  - 0x10 error address
  - 0x20 configuration
  - 0x24 status
  - 0x30 refresh
  - 0x34 power-management
  - 0x40, 0x44, 0x48, 0x4C banks 0 to 3
  - 0x80 timing
  - 0x94 ECC configuration
  - 0x98 ECC error status

  Any other offset reads zero, and a write to it changes nothing.
- R3: After reset the configuration register reads 0x00800000, power-management reads 0x07C00000, refresh reads 0x05F00000 and timing reads 0x00854009. Every other register, the index, bus_rdata, ecc_irq and ctrl_enable are zero.
- R4: Each error status register gains every bit that is high on its set input in a cycle. A data write clears the bits that are 1 in the written value. A bit that is set and cleared in the same cycle stays set.
- R5: When configuration bit 31 is written from 0 to 1, status bit 31 clears. When it is written from 1 to 0, status bit 31 sets. ctrl_enable equals configuration bit 31 from the clock after the write.
- R6: When configuration bit 30 is written from 0 to 1, status bit 30 sets. When it is written from 1 to 0, status bit 30 clears. Status bits 29 to 0 read zero.
- R7: The status register ignores data writes. It changes only on configuration writes.
- R8: Refresh stores (value AND 0x3FF80000). Timing stores (value AND 0x018FC01F). ECC configuration stores (value AND 0x00F00000). Power-management stores (value AND 0xF8000000) OR 0x07C00000. Error address, configuration and ECC error status store the full value.
- R9: Each bank register stores (value AND 0xFFDEE001).
- R10: ecc_irq becomes (value != 0) in the clock after a write of the ECC error status register. It holds otherwise.
- R11: A read of a bus address other than 0x10 and 0x11 returns zero. A write to one changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | AW (10) | Bus register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| err0_set | input | 32 | Per-bit set pulses for error status A |
| err1_set | input | 32 | Per-bit set pulses for error status B |
| ecc_irq | output | 1 | ECC error interrupt |
| ctrl_enable | output | 1 | Controller enable toward the bank decoder |

## Verification
The bench sweeps all 256 index values under several data patterns. After each write it compares the read-back value, ecc_irq and ctrl_enable against a model built from the requirements. This catches a wrong mask or a wrong forced bit, an aliased offset, and a status register that accepts writes. Alternating patterns flip configuration bits 31 and 30 in both directions and also rewrite them unchanged. A design that toggled status on level instead of on edge, or that swapped the set and clear polarity, would show a wrong status read. Set and clear of the same error bit in one cycle is driven on purpose; a design giving the clear priority would lose that bit. Sweeping the unused bus addresses exposes a decoder that ignores address bits, because it would return data or corrupt the index.

// File: rtl/sdcfg_pkg.sv
package sdcfg_pkg;
  localparam int DW = 32;
  typedef logic [DW-1:0] word_t;

  // internal offsets (software-visible map)
  localparam int OFF_ERR0  = 'h00;
  localparam int OFF_ERR1  = 'h08;
  localparam int OFF_EADDR = 'h10;
  localparam int OFF_CFG   = 'h20;
  localparam int OFF_STAT  = 'h24;
  localparam int OFF_RFSH  = 'h30;
  localparam int OFF_PWR   = 'h34;
  localparam int OFF_BANK  = 'h40;
  localparam int BANK_STEP = 4;
  localparam int OFF_TIME  = 'h80;
  localparam int OFF_ECFG  = 'h94;
  localparam int OFF_ESTAT = 'h98;

  // storage masks, forced bits and reset values
  localparam word_t ALL_ONES   = '1;
  localparam word_t RFSH_MASK  = 32'h3FF8_0000;
  localparam word_t TIME_MASK  = 32'h018F_C01F;
  localparam word_t ECFG_MASK  = 32'h00F0_0000;
  localparam word_t PWR_MASK   = 32'hF800_0000;
  localparam word_t PWR_FORCE  = 32'h07C0_0000;
  localparam word_t BANK_MASK  = 32'hFFDE_E001;
  localparam word_t CFG_RST    = 32'h0080_0000;
  localparam word_t PWR_RST    = 32'h07C0_0000;
  localparam word_t RFSH_RST   = 32'h05F0_0000;
  localparam word_t TIME_RST   = 32'h0085_4009;

  localparam int EN_BIT = 31;
  localparam int SR_BIT = 30;
endpackage

// File: rtl/sdcfg_index.sv
module sdcfg_index #(
  parameter int AW        = 10,
  parameter int IDX_W     = 8,
  parameter int IDX_ADDR  = 'h10,
  parameter int DATA_ADDR = 'h11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wr,
  input  logic [AW-1:0]    bus_addr,
  input  logic [IDX_W-1:0] idx_wdata,
  output logic [IDX_W-1:0] idx_q,
  output logic             idx_sel,
  output logic             data_sel,
  output logic             data_wr
);
  assign idx_sel  = (bus_addr == AW'(IDX_ADDR));
  assign data_sel = (bus_addr == AW'(DATA_ADDR));
  assign data_wr  = bus_wr && data_sel;

  always_ff @(posedge clk) begin
    if (rst)                  idx_q <= '0;
    else if (bus_wr && idx_sel) idx_q <= idx_wdata;
  end
endmodule

// File: rtl/sdcfg_field.sv
module sdcfg_field #(
  parameter int           W     = 32,
  parameter logic [W-1:0] MASK  = '1,
  parameter logic [W-1:0] FORCE = '0,
  parameter logic [W-1:0] RST   = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= RST;
    else if (we) q <= (d & MASK) | FORCE;
  end
endmodule

// File: rtl/sdcfg_w1c.sv
module sdcfg_w1c #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_we,
  input  logic [W-1:0] clr,
  input  logic [W-1:0] set,
  output logic [W-1:0] q
);
  logic [W-1:0] clr_eff;
  assign clr_eff = clr_we ? clr : '0;

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= (q & ~clr_eff) | set;  // hardware set wins
  end
endmodule

// File: rtl/sdcfg_status.sv
module sdcfg_status (
  input  logic clk,
  input  logic rst,
  input  logic cfg_we,
  input  logic old_en,
  input  logic old_sr,
  input  logic new_en,
  input  logic new_sr,
  output logic st_off,
  output logic st_sr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      st_off <= 1'b0;
      st_sr  <= 1'b0;
    end else if (cfg_we) begin
      if (!old_en && new_en)      st_off <= 1'b0;
      else if (old_en && !new_en) st_off <= 1'b1;
      if (!old_sr && new_sr)      st_sr  <= 1'b1;
      else if (old_sr && !new_sr) st_sr  <= 1'b0;
    end
  end
endmodule

// File: rtl/sdram_cfg_regs.sv
module sdram_cfg_regs
  import sdcfg_pkg::*;
#(
  parameter int AW        = 10,
  parameter int IDX_W     = 8,
  parameter int NUM_BANKS = 4,
  parameter int IDX_ADDR  = 'h10,
  parameter int DATA_ADDR = 'h11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic [31:0]   err0_set,
  input  logic [31:0]   err1_set,
  output logic          ecc_irq,
  output logic          ctrl_enable
);
  logic [IDX_W-1:0] idx_q;
  logic             idx_sel, data_sel, data_wr;

  sdcfg_index #(.AW(AW), .IDX_W(IDX_W), .IDX_ADDR(IDX_ADDR), .DATA_ADDR(DATA_ADDR)) u_idx (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .idx_wdata(bus_wdata[IDX_W-1:0]), .idx_q(idx_q),
    .idx_sel(idx_sel), .data_sel(data_sel), .data_wr(data_wr)
  );

  function automatic logic hit(input logic [IDX_W-1:0] i, input int off);
    return i == IDX_W'(off);
  endfunction

  logic we_err0, we_err1, we_eaddr, we_cfg, we_rfsh, we_pwr, we_time, we_ecfg, we_estat;
  assign we_err0  = data_wr && hit(idx_q, OFF_ERR0);
  assign we_err1  = data_wr && hit(idx_q, OFF_ERR1);
  assign we_eaddr = data_wr && hit(idx_q, OFF_EADDR);
  assign we_cfg   = data_wr && hit(idx_q, OFF_CFG);
  assign we_rfsh  = data_wr && hit(idx_q, OFF_RFSH);
  assign we_pwr   = data_wr && hit(idx_q, OFF_PWR);
  assign we_time  = data_wr && hit(idx_q, OFF_TIME);
  assign we_ecfg  = data_wr && hit(idx_q, OFF_ECFG);
  assign we_estat = data_wr && hit(idx_q, OFF_ESTAT);

  word_t err0_q, err1_q, eaddr_q, cfg_q, rfsh_q, pwr_q, time_q, ecfg_q, estat_q, status_q;
  logic  st_off, st_sr;

  sdcfg_w1c #(.W(DW)) u_err0 (.clk(clk), .rst(rst), .clr_we(we_err0), .clr(bus_wdata), .set(err0_set), .q(err0_q));
  sdcfg_w1c #(.W(DW)) u_err1 (.clk(clk), .rst(rst), .clr_we(we_err1), .clr(bus_wdata), .set(err1_set), .q(err1_q));

  sdcfg_field #(.W(DW)) u_eaddr (.clk(clk), .rst(rst), .we(we_eaddr), .d(bus_wdata), .q(eaddr_q));
  sdcfg_field #(.W(DW), .RST(CFG_RST)) u_cfg (.clk(clk), .rst(rst), .we(we_cfg), .d(bus_wdata), .q(cfg_q));
  sdcfg_field #(.W(DW), .MASK(RFSH_MASK), .RST(RFSH_RST)) u_rfsh (.clk(clk), .rst(rst), .we(we_rfsh), .d(bus_wdata), .q(rfsh_q));
  sdcfg_field #(.W(DW), .MASK(PWR_MASK), .FORCE(PWR_FORCE), .RST(PWR_RST)) u_pwr (.clk(clk), .rst(rst), .we(we_pwr), .d(bus_wdata), .q(pwr_q));
  sdcfg_field #(.W(DW), .MASK(TIME_MASK), .RST(TIME_RST)) u_time (.clk(clk), .rst(rst), .we(we_time), .d(bus_wdata), .q(time_q));
  sdcfg_field #(.W(DW), .MASK(ECFG_MASK)) u_ecfg (.clk(clk), .rst(rst), .we(we_ecfg), .d(bus_wdata), .q(ecfg_q));
  sdcfg_field #(.W(DW)) u_estat (.clk(clk), .rst(rst), .we(we_estat), .d(bus_wdata), .q(estat_q));

  sdcfg_status u_stat (
    .clk(clk), .rst(rst), .cfg_we(we_cfg),
    .old_en(cfg_q[EN_BIT]), .old_sr(cfg_q[SR_BIT]),
    .new_en(bus_wdata[EN_BIT]), .new_sr(bus_wdata[SR_BIT]),
    .st_off(st_off), .st_sr(st_sr)
  );
  assign status_q = {st_off, st_sr, {(DW-2){1'b0}}};

  word_t bank_q [NUM_BANKS];
  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic we_bank;
    assign we_bank = data_wr && hit(idx_q, OFF_BANK + BANK_STEP * g);
    sdcfg_field #(.W(DW), .MASK(BANK_MASK)) u_bank (
      .clk(clk), .rst(rst), .we(we_bank), .d(bus_wdata), .q(bank_q[g])
    );
  end

  // ECC interrupt follows the value written into the ECC error status
  always_ff @(posedge clk) begin
    if (rst)           ecc_irq <= 1'b0;
    else if (we_estat) ecc_irq <= |bus_wdata;
  end

  assign ctrl_enable = cfg_q[EN_BIT];

  word_t win_mux, rd_mux;
  always_comb begin
    win_mux = '0;
    if (hit(idx_q, OFF_ERR0))  win_mux = err0_q;
    if (hit(idx_q, OFF_ERR1))  win_mux = err1_q;
    if (hit(idx_q, OFF_EADDR)) win_mux = eaddr_q;
    if (hit(idx_q, OFF_CFG))   win_mux = cfg_q;
    if (hit(idx_q, OFF_STAT))  win_mux = status_q;
    if (hit(idx_q, OFF_RFSH))  win_mux = rfsh_q;
    if (hit(idx_q, OFF_PWR))   win_mux = pwr_q;
    if (hit(idx_q, OFF_TIME))  win_mux = time_q;
    if (hit(idx_q, OFF_ECFG))  win_mux = ecfg_q;
    if (hit(idx_q, OFF_ESTAT)) win_mux = estat_q;
    for (int b = 0; b < NUM_BANKS; b++)
      if (hit(idx_q, OFF_BANK + BANK_STEP * b)) win_mux = bank_q[b];
  end

  always_comb begin
    rd_mux = '0;
    if (idx_sel)       rd_mux = DW'(idx_q);
    else if (data_sel) rd_mux = win_mux;
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/sdcfg_chk.sv
module sdcfg_chk #(
  parameter int AW        = 10,
  parameter int IDX_W     = 8,
  parameter int IDX_ADDR  = 'h10,
  parameter int DATA_ADDR = 'h11
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_wr,
  input logic             bus_rd,
  input logic [AW-1:0]    bus_addr,
  input logic [31:0]      bus_wdata,
  input logic [31:0]      bus_rdata,
  input logic [31:0]      err0_set,
  input logic             ecc_irq,
  input logic             ctrl_enable,
  input logic [IDX_W-1:0] idx_q,
  input logic [31:0]      status_q,
  input logic [31:0]      err0_q
);
  logic dwr, other_addr;
  assign dwr        = bus_wr && (bus_addr == AW'(DATA_ADDR));
  assign other_addr = (bus_addr != AW'(DATA_ADDR)) && (bus_addr != AW'(IDX_ADDR));

  p_enable_follows_r5: assert property (@(posedge clk) disable iff (rst)
    (dwr && idx_q == IDX_W'('h20)) |=> (ctrl_enable == $past(bus_wdata[31])));

  p_status31_rise_r5: assert property (@(posedge clk) disable iff (rst)
    (dwr && idx_q == IDX_W'('h20) && !ctrl_enable && bus_wdata[31]) |=> !status_q[31]);

  p_status_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !(dwr && idx_q == IDX_W'('h20)) |=> $stable(status_q));

  p_err_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (dwr && idx_q == IDX_W'('h00) && err0_set == '0) |=> ((err0_q & $past(bus_wdata)) == '0));

  p_irq_write_r10: assert property (@(posedge clk) disable iff (rst)
    (dwr && idx_q == IDX_W'('h98)) |=> (ecc_irq == ($past(bus_wdata) != '0)));

  p_irq_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !(dwr && idx_q == IDX_W'('h98)) |=> $stable(ecc_irq));

  p_other_read_zero_r11: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && other_addr) |=> (bus_rdata == '0));

  p_index_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_addr == AW'(IDX_ADDR)) |=> $stable(idx_q));
endmodule

bind sdram_cfg_regs sdcfg_chk #(.AW(AW), .IDX_W(IDX_W), .IDX_ADDR(IDX_ADDR), .DATA_ADDR(DATA_ADDR)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .err0_set(err0_set),
  .ecc_irq(ecc_irq), .ctrl_enable(ctrl_enable), .idx_q(idx_q),
  .status_q(status_q), .err0_q(err0_q)
);

// File: tb/tb_sdram_cfg_regs.sv
module tb_sdram_cfg_regs;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        b_wr = 1'b0, b_rd = 1'b0;
  logic [9:0]  b_addr = '0;
  logic [31:0] b_wdata = '0;
  logic [31:0] b_rdata;
  logic [31:0] e0_set = '0, e1_set = '0;
  logic        irq, en;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  sdram_cfg_regs dut (
    .clk(clk), .rst(rst), .bus_wr(b_wr), .bus_rd(b_rd), .bus_addr(b_addr),
    .bus_wdata(b_wdata), .bus_rdata(b_rdata), .err0_set(e0_set), .err1_set(e1_set),
    .ecc_irq(irq), .ctrl_enable(en)
  );

  // model built from the requirements
  logic [31:0] m_err0, m_err1, m_eaddr, m_cfg, m_stat, m_rfsh, m_pwr, m_time, m_ecfg, m_estat;
  logic [31:0] m_bank [4];

  task automatic model_reset();
    m_err0 = 0; m_err1 = 0; m_eaddr = 0; m_stat = 0; m_ecfg = 0; m_estat = 0;
    m_cfg = 32'h0080_0000; m_pwr = 32'h07C0_0000; m_rfsh = 32'h05F0_0000; m_time = 32'h0085_4009;
    for (int i = 0; i < 4; i++) m_bank[i] = 0;
  endtask

  task automatic model_write(input int off, input logic [31:0] v);
    case (off)
      'h00: m_err0 &= ~v;
      'h08: m_err1 &= ~v;
      'h10: m_eaddr = v;
      'h20: begin
        if (!m_cfg[31] && v[31]) m_stat[31] = 1'b0;
        else if (m_cfg[31] && !v[31]) m_stat[31] = 1'b1;
        if (!m_cfg[30] && v[30]) m_stat[30] = 1'b1;
        else if (m_cfg[30] && !v[30]) m_stat[30] = 1'b0;
        m_cfg = v;
      end
      'h30: m_rfsh = v & 32'h3FF8_0000;
      'h34: m_pwr = (v & 32'hF800_0000) | 32'h07C0_0000;
      'h40, 'h44, 'h48, 'h4C: m_bank[(off - 'h40) / 4] = v & 32'hFFDE_E001;
      'h80: m_time = v & 32'h018F_C01F;
      'h94: m_ecfg = v & 32'h00F0_0000;
      'h98: m_estat = v;
      default: ;
    endcase
  endtask

  function automatic logic [31:0] model_read(input int off);
    case (off)
      'h00: return m_err0;
      'h08: return m_err1;
      'h10: return m_eaddr;
      'h20: return m_cfg;
      'h24: return m_stat;
      'h30: return m_rfsh;
      'h34: return m_pwr;
      'h40, 'h44, 'h48, 'h4C: return m_bank[(off - 'h40) / 4];
      'h80: return m_time;
      'h94: return m_ecfg;
      'h98: return m_estat;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string req_of(input int off);
    case (off)
      'h00, 'h08: return "R4";
      'h20: return "R5";
      'h24: return "R7";
      'h30, 'h34, 'h80, 'h94, 'h10: return "R8";
      'h40, 'h44, 'h48, 'h4C: return "R9";
      'h98: return "R10";
      default: return "R2";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%08h expected=%08h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk); b_wr = 1'b1; b_addr = a; b_wdata = d;
    @(negedge clk); b_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk); b_rd = 1'b1; b_addr = a;
    @(negedge clk); b_rd = 1'b0; d = b_rdata;
  endtask

  task automatic read_off(input int off, output logic [31:0] d);
    bus_write(10'h10, 32'(off));
    bus_read(10'h11, d);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d, v, held;
    logic [31:0] pats [5];
    pats[0] = 32'hFFFF_FFFF; pats[1] = 32'h0000_0000; pats[2] = 32'hA5A5_A5A5;
    pats[3] = 32'h5A5A_5A5A; pats[4] = 32'hC000_0000;

    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    model_reset();
    // R3: outputs right after reset
    check("R3", b_rdata, 32'h0, "rdata after reset");
    check("R3", {31'b0, irq}, 32'h0, "ecc_irq after reset");
    check("R3", {31'b0, en}, 32'h0, "ctrl_enable after reset");
    bus_read(10'h10, d);
    check("R3", d, 32'h0, "index after reset");
    // R3: every offset reads its reset value
    for (int off = 0; off < 256; off++) begin
      read_off(off, d);
      check(off == 'h20 || off == 'h30 || off == 'h34 || off == 'h80 ? "R3" : req_of(off),
            d, model_read(off), $sformatf("reset value off %02h", off));
    end

    // R1: index write/read back, and read data holds without a strobe
    for (int k = 0; k < 256; k += 37) begin
      bus_write(10'h10, 32'hFFFF_FF00 | 32'(k));
      bus_read(10'h10, d);
      check("R1", d, 32'(k), "index readback");
      @(negedge clk);
      check("R1", b_rdata, 32'(k), "rdata holds");
    end

    // R2/R5/R6/R7/R8/R9/R10: sweep all offsets under several patterns
    for (int p = 0; p < 5; p++) begin
      for (int off = 0; off < 256; off++) begin
        v = pats[p] ^ {4{8'(off)}};
        if (p == 4) v = pats[p] ^ 32'(off);
        bus_write(10'h10, 32'(off));
        bus_write(10'h11, v);
        model_write(off, v);
        bus_read(10'h11, d);
        check(req_of(off), d, model_read(off), $sformatf("sweep p%0d off %02h", p, off));
        check("R5", {31'b0, en}, {31'b0, m_cfg[31]}, "ctrl_enable");
        check("R10", {31'b0, irq}, {31'b0, m_estat != 0}, "ecc_irq");
        if (off == 'h20) begin
          read_off('h24, d);
          check("R6", d, m_stat, $sformatf("status after cfg p%0d", p));
        end
      end
    end

    // R5/R6: explicit edges of configuration bits 31 and 30
    bus_write(10'h10, 32'h20); bus_write(10'h11, 32'h0); model_write('h20, 32'h0);
    bus_write(10'h11, 32'h8000_0000); model_write('h20, 32'h8000_0000);
    read_off('h24, d); check("R5", d, 32'h0, "status31 cleared on enable");
    bus_write(10'h10, 32'h20);
    bus_write(10'h11, 32'h4000_0000); model_write('h20, 32'h4000_0000);
    read_off('h24, d); check("R6", d, 32'hC000_0000, "status31 set, status30 set");
    check("R5", {31'b0, en}, 32'h0, "ctrl_enable low after disable");
    bus_write(10'h10, 32'h20);
    bus_write(10'h11, 32'h4000_0000); model_write('h20, 32'h4000_0000);
    read_off('h24, d); check("R6", d, 32'hC000_0000, "no change without edge");

    // R4: hardware set, partial clear, simultaneous set and clear
    @(negedge clk); e0_set = 32'hF0F0_1234; e1_set = 32'h0000_8001;
    @(negedge clk); e0_set = 0; e1_set = 0;
    read_off('h00, d); check("R4", d, 32'hF0F0_1234, "err A set");
    read_off('h08, d); check("R4", d, 32'h0000_8001, "err B set");
    bus_write(10'h10, 32'h00); bus_write(10'h11, 32'h0000_1230);
    read_off('h00, d); check("R4", d, 32'hF0F0_0004, "err A partial clear");
    bus_write(10'h10, 32'h00);
    @(negedge clk); b_wr = 1'b1; b_addr = 10'h11; b_wdata = 32'hFFFF_FFFF; e0_set = 32'h0000_0100;
    @(negedge clk); b_wr = 1'b0; e0_set = 0;
    read_off('h00, d); check("R4", d, 32'h0000_0100, "set beats clear");

    // R11: other bus addresses read zero and change nothing
    bus_write(10'h10, 32'h34);
    bus_read(10'h11, held);
    for (int a = 0; a < 1024; a += 7) begin
      if (a == 'h10 || a == 'h11) continue;
      bus_write(10'(a), 32'hDEAD_BEEF);
      bus_read(10'(a), d);
      check("R11", d, 32'h0, $sformatf("read of bus addr %03h", a));
    end
    bus_read(10'h10, d); check("R11", d, 32'h34, "index unchanged");
    bus_read(10'h11, d); check("R11", d, held, "register unchanged");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule